// File: doc/BRIEF.md
# External Bus Chip-Select Timing Controller

This block sequences the strobes of one external memory area on a bus with separate address and data lines. All timing is counted on the external bus clock. An internal master presents a read or write request. The controller then drives an active-low chip select, read strobe and write strobe, and it holds the address, the write data and a data-output enable. It captures read data, and it can stretch the access while an active-low external wait input is held low. For each beat it returns a done pulse, and for reads it also returns the captured data.

Software-visible settings arrive as static configuration inputs:
- a main wait count, set separately for reads and writes;
- independent assert delays for chip select, read strobe, write strobe and write-data drive;
- a chip-select negate extension, set separately for reads and writes;
- a write-data hold extension.

A page (burst) access is a chain of beats that share one chip-select assertion. The master marks the final beat with a flag.

Top module: `xbus_cs_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it, `csN`, `rdN` and `wrN` are 1, `busOe` is 0 and `done` is 0. Reset is synchronous and active low. After reset, `reqReady` is 1.
- R2: Access cycle 0 is the cycle after the clock edge that accepts a request. With main wait W, the strobe-valid cycle is cycle W, where W is `cfgRdWait` for reads and `cfgWrWait` for writes. RD or WR goes high again in cycle W+1.
- R3: Chip select, RD, WR and the write-data enable each first assert in cycle min(D, W), where D is the delay of that signal. A delay larger than W is clamped to W.
- R4: `done` is 1 for exactly one cycle per beat, in the cycle after the final strobe-valid cycle. For reads, `rdData` then holds the value that `busRdata` had in that final strobe-valid cycle.
- R5: With `cfgExtWaitEn`=1, each strobe-valid cycle in which `extWaitN` is sampled low is repeated. The strobe stays asserted and `done` stays low until `extWaitN` is sampled high.
- R6: After the final strobe-valid cycle, chip select stays low for E more cycles. E is `cfgCsRdExt` for reads and `cfgCsWrExt` for writes. Chip select is therefore high in cycle W+1+E of a single access.
- R7: On writes, `busOe` is high from cycle min(`cfgWdDly`,W) through X cycles after the strobe-valid cycle, where X is `cfgWdExt`. On reads `busOe` stays 0. `busAddr` and `busWdata` keep the accepted values until the next request is accepted.
- R8: When the beat is not the last (`reqLast`=0), the next beat is accepted at the end of the strobe-valid cycle, so its cycle 0 directly follows. Chip select stays low between beats.
- R9: On a page write with a nonzero `cfgWdExt`, X extension cycles come between beats. In those cycles WR is high and chip select and `busOe` stay asserted.
- R10: Between page beats, RD or WR goes high in the next beat's early cycles only if its assert delay is nonzero. With a zero delay it stays low without a break.
- R11: `reqReady` is 0 while a single access still holds chip select low. A request is taken only in idle, or at a page-beat boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Master request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLast | input | 1 | 1 = final beat of the access |
| reqAddr | input | AW | Request address |
| reqWdata | input | DW | Request write data |
| reqReady | output | 1 | Request can be accepted this cycle |
| done | output | 1 | One-cycle beat completion pulse |
| rdData | output | DW | Captured read data |
| cfgRdWait | input | WAIT_W | Main wait count for reads |
| cfgWrWait | input | WAIT_W | Main wait count for writes |
| cfgCsDly | input | DLY_W | Chip-select assert delay |
| cfgRdDly | input | DLY_W | Read strobe assert delay |
| cfgWrDly | input | DLY_W | Write strobe assert delay |
| cfgWdDly | input | DLY_W | Write-data drive delay |
| cfgCsRdExt | input | DLY_W | Chip-select extension after reads |
| cfgCsWrExt | input | DLY_W | Chip-select extension after writes |
| cfgWdExt | input | DLY_W | Write-data hold extension |
| cfgExtWaitEn | input | 1 | Enables the external wait input |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| busAddr | output | AW | External address |
| busWdata | output | DW | External write data |
| busOe | output | 1 | Write-data output enable |
| busRdata | input | DW | External read data |
| extWaitN | input | 1 | Active-low external wait |

## Verification
Two things can land in the same cycle: the last strobe-valid cycle of a stretched read, and the capture of read data. The bench holds `extWaitN` low across two repeats of the strobe-valid cycle. It then releases the wait and changes `busRdata` in the same cycle. The capture is correct only if `rdData` shows the value from that final cycle, and if `done` and the RD negation both appear exactly one cycle later. The second collision is at a page boundary, where one beat's done pulse coincides with the next beat's early cycles. This is judged by checking that chip select never rises and that the new address is already on the bus in the next strobe-valid cycle.

// File: rtl/xbus_cs_pkg.sv
`timescale 1ns/1ps
package xbus_cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_STRB = 3'd2,
    ST_TAIL = 3'd3,
    ST_HOLD = 3'd4
  } xbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // sample read data
    logic beatEnd;  // final strobe-valid cycle of a beat
    logic csAct;
    logic rdAct;
    logic wrAct;
    logic oeAct;
  } xbCtl_t;

endpackage

// File: rtl/xbus_cs_ctrl.sv
`timescale 1ns/1ps
module xbus_cs_ctrl
  import xbus_cs_pkg::*;
#(
  parameter int WAIT_W = 5,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLast,
  output logic              reqReady,
  input  logic [WAIT_W-1:0] cfgRdWait,
  input  logic [WAIT_W-1:0] cfgWrWait,
  input  logic [DLY_W-1:0]  cfgCsDly,
  input  logic [DLY_W-1:0]  cfgRdDly,
  input  logic [DLY_W-1:0]  cfgWrDly,
  input  logic [DLY_W-1:0]  cfgWdDly,
  input  logic [DLY_W-1:0]  cfgCsRdExt,
  input  logic [DLY_W-1:0]  cfgCsWrExt,
  input  logic [DLY_W-1:0]  cfgWdExt,
  input  logic              cfgExtWaitEn,
  input  logic              extWaitN,
  output xbCtl_t            ctl
);

  localparam int PAD = WAIT_W - DLY_W;

  function automatic logic [WAIT_W-1:0] widen(input logic [DLY_W-1:0] d);
    return {{PAD{1'b0}}, d};
  endfunction

  function automatic logic [WAIT_W-1:0] clampTo(input logic [DLY_W-1:0] d,
                                                input logic [WAIT_W-1:0] lim);
    return (widen(d) > lim) ? lim : widen(d);
  endfunction

  xbState_e          state;
  logic [WAIT_W-1:0] cnt;
  logic              curWrite, curLast, inPage;

  logic [WAIT_W-1:0] waitSel, newWait, csExtW, wdExtW, tailLen, tailEnd;
  logic [WAIT_W-1:0] csDc, rdDc, wrDc, wdDc;
  logic              waitOk, strbDone, tailDone, gapFree, pageReady, accept;

  always_comb begin
    waitSel  = curWrite ? cfgWrWait : cfgRdWait;
    newWait  = reqWrite ? cfgWrWait : cfgRdWait;
    csExtW   = widen(curWrite ? cfgCsWrExt : cfgCsRdExt);
    wdExtW   = curWrite ? widen(cfgWdExt) : '0;
    tailLen  = (csExtW > wdExtW) ? csExtW : wdExtW;
    tailEnd  = curLast ? tailLen : wdExtW;
    csDc     = clampTo(cfgCsDly, waitSel);
    rdDc     = clampTo(cfgRdDly, waitSel);
    wrDc     = clampTo(cfgWrDly, waitSel);
    wdDc     = clampTo(cfgWdDly, waitSel);
    waitOk   = !cfgExtWaitEn || extWaitN;
    strbDone = (state == ST_STRB) && waitOk;
    tailDone = (state == ST_TAIL) && (cnt == tailEnd - 1'b1);
    gapFree  = strbDone && !curLast && (wdExtW == '0);
    pageReady = gapFree || (tailDone && !curLast) || (state == ST_HOLD);
    reqReady = (state == ST_IDLE) || pageReady;
    accept   = reqValid && reqReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      curWrite <= 1'b0;
      curLast  <= 1'b1;
      inPage   <= 1'b0;
    end else if (accept) begin
      state    <= (newWait == '0) ? ST_STRB : ST_WAIT;
      cnt      <= '0;
      curWrite <= reqWrite;
      curLast  <= reqLast;
      inPage   <= (state != ST_IDLE);
    end else begin
      case (state)
        ST_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == waitSel - 1'b1) state <= ST_STRB;
        end
        ST_STRB: begin
          if (strbDone) begin
            cnt <= '0;
            if (gapFree)                          state <= ST_HOLD;
            else if (!curLast || tailLen != '0)   state <= ST_TAIL;
            else                                  state <= ST_IDLE;
          end
        end
        ST_TAIL: begin
          if (tailDone) state <= curLast ? ST_IDLE : ST_HOLD;
          else          cnt   <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.capture = strbDone && !curWrite;
    ctl.beatEnd = strbDone;
    case (state)
      ST_WAIT: begin
        ctl.csAct = inPage || (cnt >= csDc);
        ctl.rdAct = !curWrite && (cnt >= rdDc);
        ctl.wrAct = curWrite && (cnt >= wrDc);
        ctl.oeAct = curWrite && (cnt >= wdDc);
      end
      ST_STRB: begin
        ctl.csAct = 1'b1;
        ctl.rdAct = !curWrite;
        ctl.wrAct = curWrite;
        ctl.oeAct = curWrite;
      end
      ST_TAIL: begin
        ctl.csAct = !curLast || (cnt < csExtW);
        ctl.oeAct = cnt < wdExtW;
      end
      ST_HOLD: ctl.csAct = 1'b1;
      default: ;
    endcase
  end

  // R5: a low wait sample repeats the strobe-valid cycle
  a_r5_stretch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STRB && cfgExtWaitEn && !extWaitN) |=> (state == ST_STRB));

  // R2: strobes are negated once the strobe-valid phase is left
  a_r2_tail_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL) |-> !(ctl.rdAct || ctl.wrAct));

  // R2: the wait counter stays below the selected main wait
  a_r2_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (cnt < waitSel));

  // R8: chip select held while waiting for the next page beat
  a_r8_hold_cs: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> ctl.csAct);

  // R11: no request taken in the middle of the wait period
  a_r11_busy_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !reqReady);

endmodule

// File: rtl/xbus_cs_dpath.sv
`timescale 1ns/1ps
module xbus_cs_dpath
  import xbus_cs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  xbCtl_t        ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busRdata,
  output logic          csN,
  output logic          rdN,
  output logic          wrN,
  output logic          busOe,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic [DW-1:0] rdData,
  output logic          done
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ, rdQ;
  logic          doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= ctl.beatEnd;
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdQ <= busRdata;
    end
  end

  assign csN      = ~ctl.csAct;
  assign rdN      = ~ctl.rdAct;
  assign wrN      = ~ctl.wrAct;
  assign busOe    = ctl.oeAct;
  assign busAddr  = addrQ;
  assign busWdata = wdataQ;
  assign rdData   = rdQ;
  assign done     = doneQ;

  // R7: address and write data hold until a new request is latched
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(busAddr) && $stable(busWdata)));

  // R4: read data only changes on a capture
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rdData));

endmodule

// File: rtl/xbus_cs_timer.sv
`timescale 1ns/1ps
module xbus_cs_timer
  import xbus_cs_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WAIT_W = 5,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLast,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic [DW-1:0]     rdData,
  input  logic [WAIT_W-1:0] cfgRdWait,
  input  logic [WAIT_W-1:0] cfgWrWait,
  input  logic [DLY_W-1:0]  cfgCsDly,
  input  logic [DLY_W-1:0]  cfgRdDly,
  input  logic [DLY_W-1:0]  cfgWrDly,
  input  logic [DLY_W-1:0]  cfgWdDly,
  input  logic [DLY_W-1:0]  cfgCsRdExt,
  input  logic [DLY_W-1:0]  cfgCsWrExt,
  input  logic [DLY_W-1:0]  cfgWdExt,
  input  logic              cfgExtWaitEn,
  output logic              csN,
  output logic              rdN,
  output logic              wrN,
  output logic [AW-1:0]     busAddr,
  output logic [DW-1:0]     busWdata,
  output logic              busOe,
  input  logic [DW-1:0]     busRdata,
  input  logic              extWaitN
);

  xbCtl_t ctl;

  xbus_cs_ctrl #(.WAIT_W(WAIT_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLast(reqLast),
    .reqReady(reqReady),
    .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait),
    .cfgCsDly(cfgCsDly), .cfgRdDly(cfgRdDly), .cfgWrDly(cfgWrDly),
    .cfgWdDly(cfgWdDly), .cfgCsRdExt(cfgCsRdExt), .cfgCsWrExt(cfgCsWrExt),
    .cfgWdExt(cfgWdExt), .cfgExtWaitEn(cfgExtWaitEn), .extWaitN(extWaitN),
    .ctl(ctl)
  );

  xbus_cs_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busRdata(busRdata),
    .csN(csN), .rdN(rdN), .wrN(wrN), .busOe(busOe),
    .busAddr(busAddr), .busWdata(busWdata), .rdData(rdData), .done(done)
  );

endmodule

// File: tb/sim_xbus_cs_timer.sv
`timescale 1ns/1ps
module sim_xbus_cs_timer;

  localparam logic [15:0] ADDR_A = 16'h1230;
  localparam logic [15:0] ADDR_B = 16'h4568;
  localparam logic [15:0] DATA_A = 16'hC0DE;
  localparam logic [15:0] DATA_B = 16'h7E57;
  localparam int NC = 64;

  typedef struct packed {
    logic [7:0] wr, wt, csD, stD, wdD, csX, wdX;
    logic [7:0] eCs, eSt, eStH, eCsH, eDone, eOe, eOeH;
  } vec_t;

  // stimulus | expected first-cycle indices (63 = never)
  localparam vec_t VEC [0:5] = '{
    '{8'd0, 8'd0,  8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd1,  8'd1,  8'd1,  8'd63, 8'd63},
    '{8'd0, 8'd5,  8'd1, 8'd3, 8'd0, 8'd2, 8'd0,  8'd1, 8'd3, 8'd6,  8'd8,  8'd6,  8'd63, 8'd63},
    '{8'd1, 8'd4,  8'd0, 8'd2, 8'd1, 8'd1, 8'd3,  8'd0, 8'd2, 8'd5,  8'd6,  8'd5,  8'd1,  8'd8},
    '{8'd0, 8'd2,  8'd5, 8'd7, 8'd0, 8'd0, 8'd0,  8'd2, 8'd2, 8'd3,  8'd3,  8'd3,  8'd63, 8'd63},
    '{8'd1, 8'd31, 8'd7, 8'd7, 8'd0, 8'd7, 8'd0,  8'd7, 8'd7, 8'd32, 8'd39, 8'd32, 8'd0,  8'd32},
    '{8'd1, 8'd0,  8'd0, 8'd3, 8'd2, 8'd0, 8'd2,  8'd0, 8'd0, 8'd1,  8'd1,  8'd1,  8'd0,  8'd3}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, reqValid, reqWrite, reqLast, reqReady, done;
  logic [15:0] reqAddr, reqWdata, rdData, busAddr, busWdata, busRdata;
  logic [4:0]  cfgRdWait, cfgWrWait;
  logic [2:0]  cfgCsDly, cfgRdDly, cfgWrDly, cfgWdDly, cfgCsRdExt, cfgCsWrExt, cfgWdExt;
  logic        cfgExtWaitEn, csN, rdN, wrN, busOe, extWaitN;

  xbus_cs_timer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLast(reqLast), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .done(done), .rdData(rdData),
    .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait), .cfgCsDly(cfgCsDly),
    .cfgRdDly(cfgRdDly), .cfgWrDly(cfgWrDly), .cfgWdDly(cfgWdDly),
    .cfgCsRdExt(cfgCsRdExt), .cfgCsWrExt(cfgCsWrExt), .cfgWdExt(cfgWdExt),
    .cfgExtWaitEn(cfgExtWaitEn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busAddr(busAddr), .busWdata(busWdata), .busOe(busOe),
    .busRdata(busRdata), .extWaitN(extWaitN)
  );

  typedef logic bitArr_t [NC];
  bitArr_t recCs, recRd, recWr, recOe, recDone, recRdy, stArr;
  logic [15:0] recAddr [NC];
  logic [15:0] recWd   [NC];
  logic [15:0] recRdat [NC];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int findv(input bitArr_t a, input logic val, input int from);
    for (int c = from; c < NC; c++) if (a[c] === val) return c;
    return 63;
  endfunction

  task automatic startReq(input logic wr, input logic last,
                          input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqLast = last; reqAddr = a; reqWdata = d;
  endtask

  // cycle 0 is the cycle after the accepting edge
  task automatic runCycles(input int n, input int relC, input int pgSwitch, input int pgStop);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      recCs[c] = csN;  recRd[c] = rdN;  recWr[c] = wrN;  recOe[c] = busOe;
      recDone[c] = done; recRdy[c] = reqReady;
      recAddr[c] = busAddr; recWd[c] = busWdata; recRdat[c] = rdData;
      if (c == pgSwitch) begin reqLast = 1'b1; reqAddr = ADDR_B; reqWdata = DATA_B; end
      if (c == pgStop) reqValid = 1'b0;
      if (c == relC) begin extWaitN = 1'b1; busRdata = 16'hBEEF; end
      if (c == relC + 1) busRdata = 16'h0000;
    end
  endtask

  task automatic baseCfg();
    cfgRdWait = 5'd0; cfgWrWait = 5'd0; cfgCsDly = 3'd0; cfgRdDly = 3'd0;
    cfgWrDly = 3'd0; cfgWdDly = 3'd0; cfgCsRdExt = 3'd0; cfgCsWrExt = 3'd0;
    cfgWdExt = 3'd0; cfgExtWaitEn = 1'b0; extWaitN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqLast = 1'b1;
    reqAddr = '0; reqWdata = '0; busRdata = 16'h0BAD;
    baseCfg();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 csN in reset", csN, 1);
    chk("R1 rdN/wrN in reset", {rdN, wrN}, 3);
    chk("R1 busOe in reset", busOe, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 ready after reset", reqReady, 1);
    chk("R1 csN after reset", csN, 1);

    // table-driven single accesses
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int aCs, aSt, aStH, aCsH, aDone, aOe, aOeH, nDone, nBusy;
      v = VEC[i];
      baseCfg();
      cfgRdWait  = v.wr[0] ? 5'd9 : v.wt[4:0];
      cfgWrWait  = v.wr[0] ? v.wt[4:0] : 5'd9;
      cfgCsDly   = v.csD[2:0];
      cfgRdDly   = v.wr[0] ? 3'd1 : v.stD[2:0];
      cfgWrDly   = v.wr[0] ? v.stD[2:0] : 3'd1;
      cfgWdDly   = v.wdD[2:0];
      cfgCsRdExt = v.wr[0] ? 3'd6 : v.csX[2:0];
      cfgCsWrExt = v.wr[0] ? v.csX[2:0] : 3'd6;
      cfgWdExt   = v.wr[0] ? v.wdX[2:0] : 3'd5;
      startReq(v.wr[0], 1'b1, ADDR_A + 16'(i), DATA_A ^ 16'(i));
      runCycles(NC, -10, -1, 0);
      if (v.wr[0]) stArr = recWr; else stArr = recRd;
      aCs  = findv(recCs, 1'b0, 0);
      aSt  = findv(stArr, 1'b0, 0);
      aStH = findv(stArr, 1'b1, aSt + 1);
      aCsH = findv(recCs, 1'b1, aCs + 1);
      aDone = findv(recDone, 1'b1, 0);
      aOe  = findv(recOe, 1'b1, 0);
      aOeH = findv(recOe, 1'b0, aOe + 1);
      nDone = 0; nBusy = 0;
      for (int c = 0; c < NC; c++) begin
        if (recDone[c]) nDone++;
        if (!recCs[c] && recRdy[c]) nBusy++;
      end
      chk("R3 cs assert cycle", aCs, int'(v.eCs));
      chk("R3 strobe assert cycle", aSt, int'(v.eSt));
      chk("R2 strobe negate cycle", aStH, int'(v.eStH));
      chk("R6 cs negate cycle", aCsH, int'(v.eCsH));
      chk("R4 done cycle", aDone, int'(v.eDone));
      chk("R4 done count", nDone, 1);
      chk("R7 oe assert cycle", aOe, int'(v.eOe));
      chk("R7 oe negate cycle", aOeH, int'(v.eOeH));
      chk("R7 address held", int'(recAddr[aSt]), int'(ADDR_A + 16'(i)));
      chk("R11 no ready while cs low", nBusy, 0);
    end

    // R5 / R4: external wait stretch with data change at release
    baseCfg();
    cfgRdWait = 5'd1; cfgExtWaitEn = 1'b1; extWaitN = 1'b0; busRdata = 16'h0BAD;
    startReq(1'b0, 1'b1, ADDR_A, DATA_A);
    runCycles(16, 3, -1, 0);
    chk("R5 rdN low while stretched", recRd[3], 0);
    chk("R5 done held off", recDone[3], 0);
    chk("R5 rdN high after release", recRd[4], 1);
    chk("R4 done after release", recDone[4], 1);
    chk("R4 read data from final cycle", int'(recRdat[4]), 16'hBEEF);
    chk("R6 cs high with zero extension", recCs[4], 1);
    busRdata = 16'h0BAD;

    // R8 / R10: page read, nonzero read delay
    baseCfg();
    cfgRdWait = 5'd1; cfgRdDly = 3'd1; cfgCsRdExt = 3'd1;
    startReq(1'b0, 1'b0, ADDR_A, DATA_A);
    runCycles(16, -10, 0, 2);
    chk("R8 cs low across beats", {recCs[0], recCs[1], recCs[2], recCs[3], recCs[4]}, 0);
    chk("R6 cs high after page", recCs[5], 1);
    chk("R10 rdN pattern with delay", {recRd[0], recRd[1], recRd[2], recRd[3], recRd[4]}, 5'b10101);
    chk("R8 done per beat", {recDone[2], recDone[3], recDone[4]}, 3'b101);
    chk("R8 second address", int'(recAddr[3]), int'(ADDR_B));

    // R10: page read, zero read delay
    baseCfg();
    cfgRdWait = 5'd1; cfgCsRdExt = 3'd1;
    startReq(1'b0, 1'b0, ADDR_A, DATA_A);
    runCycles(16, -10, 0, 2);
    chk("R10 rdN stays low", {recRd[0], recRd[1], recRd[2], recRd[3], recRd[4]}, 5'b00001);

    // R9: page write with data hold extension
    baseCfg();
    cfgWdExt = 3'd2; cfgRdWait = 5'd7;
    startReq(1'b1, 1'b0, ADDR_A, DATA_A);
    runCycles(16, -10, 0, 3);
    chk("R9 wrN pattern", {recWr[0], recWr[1], recWr[2], recWr[3], recWr[4]}, 5'b01101);
    chk("R9 cs low through gap", {recCs[0], recCs[1], recCs[2], recCs[3], recCs[4]}, 5'b00001);
    chk("R9 oe held", {recOe[0], recOe[2], recOe[5], recOe[6]}, 4'b1110);
    chk("R9 second data", int'(recWd[3]), int'(DATA_B));
    chk("R9 done per beat", {recDone[1], recDone[2], recDone[4]}, 3'b101);

    // R1: reset in the middle of an access
    baseCfg();
    cfgWrWait = 5'd20;
    startReq(1'b1, 1'b1, ADDR_A, DATA_A);
    runCycles(8, -10, -1, 0);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 strobes after mid reset", {csN, rdN, wrN, busOe}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after mid reset", reqReady, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule